// File: doc/BRIEF.md
# Split-Transaction Timeout and Bus Time Registers

This block holds a node's split-transaction timeout setting and its bus-time counter. Both are reached through one quadlet register port. A request carries an address, a byte length, a write flag and write data. The block answers one cycle later with read data and a response code.

From the two timeout registers the block continuously produces an expiry interval in microseconds. The interval is never allowed to fall below a minimum. The cycle timer itself is generated elsewhere and arrives as a 32-bit input. Every read of the cycle-time or bus-time register samples that input. When the new sample is smaller than the previous one, the counter has wrapped, and the bus time advances by one second step.

The register window occupies the low byte offsets: 0x0 timeout seconds, 0x4 timeout fraction, 0x8 cycle time, 0xC bus time. Every other aligned offset in the window is unmapped.

Top module: `split_bustime_regs`

## Requirements
- R1: After reset the seconds register reads 0, the fraction register reads 800 << 19, the bus time reads 0 and the expiry output is 100000.
- R2: A write to offset 0x0 keeps only write-data bits 2:0. A read returns them in bits 2:0 with all other bits zero.
- R3: A write to offset 0x4 keeps only write-data bits 31:19. These bits count 125 µs ticks, and a read returns them in place with bits 18:0 zero.
- R4: The expiry output equals seconds × 1000000 + ticks × 125, except that any result below 100000 is raised to 100000.
- R5: A read of offset 0x8 returns the cycle-time input. If that input is less than the sample stored by the previous cycle-time or bus-time read, the bus time grows by 128. The input then becomes the stored sample.
- R6: A read of offset 0xC applies the same wrap test and increment first. It then returns the updated bus time ORed with the cycle-time input shifted right by 25.
- R7: A write to offset 0xC stores the write data with bits 6:0 cleared.
- R8: An access whose address bits 1:0 or length bits 1:0 are nonzero answers with code 1 (type error) and changes no register.
- R9: A write to offset 0x8 answers with code 1 and changes no register.
- R10: An aligned access to any offset of 0x10 or above answers with code 2 (address error) and changes no register.
- R11: Every request produces `rsp_valid` on the next cycle. A successful access answers with code 0. Error responses and write responses carry read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the register window |
| req_len | input | LEN_W | Access length in bytes |
| req_wdata | input | 32 | Write data |
| cycle_time_in | input | 32 | Current cycle-timer value |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_code | output | 2 | 0 complete, 1 type error, 2 address error |
| rsp_rdata | output | 32 | Read data |
| expire_us | output | EXP_W | Split-transaction expiry in microseconds |

## Verification
Two functions coincide on a single bus-time read: the wrap increment and the splice of the top seven cycle-time bits into the returned value. The bench provokes this by feeding a cycle-time sample below the stored one together with high-order bits set, such as 0xFE000000 after a large sample. It then judges that the returned word holds both the incremented bus time and the spliced bits, with no carry between the two fields. Sweeps over every seconds value, over tick values around the clamp, and over every address and length are compared against an arithmetic model kept in the bench.

// File: rtl/split_bustime_regs.sv
module split_bustime_regs #(
  parameter int ADDR_W         = 8,
  parameter int LEN_W          = 10,
  parameter int EXP_W          = 24,
  parameter int MIN_EXPIRE_US  = 100000,
  parameter int US_PER_SEC     = 1000000,
  parameter int US_PER_TICK    = 125,
  parameter int RESET_TICKS    = 800,
  parameter int WRAP_STEP      = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [31:0]       req_wdata,
  input  logic [31:0]       cycle_time_in,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [31:0]       rsp_rdata,
  output logic [EXP_W-1:0]  expire_us
);
  localparam int TICK_LSB = 19;
  localparam int TICK_W   = 32 - TICK_LSB;
  localparam int SPLICE   = 25;
  localparam logic [1:0] RC_OK = 2'd0, RC_TYPE = 2'd1, RC_ADDR = 2'd2;

  logic [2:0]        sec_q;
  logic [TICK_W-1:0] ticks_q;
  logic [31:0]       bus_q;
  logic [31:0]       last_cyc_q;

  logic aligned, mapped, sel_sec, sel_tick, sel_cyc, sel_bus, wrapped, sample;
  logic [31:0] bus_adv;
  logic [1:0]  code_d;
  logic [31:0] rdata_d;
  logic [EXP_W-1:0] raw_us;

  assign aligned  = (req_addr[1:0] == 2'b00) && (req_len[1:0] == 2'b00);
  assign mapped   = (req_addr[ADDR_W-1:4] == '0);
  assign sel_sec  = mapped && req_addr[3:2] == 2'd0;
  assign sel_tick = mapped && req_addr[3:2] == 2'd1;
  assign sel_cyc  = mapped && req_addr[3:2] == 2'd2;
  assign sel_bus  = mapped && req_addr[3:2] == 2'd3;
  assign wrapped  = cycle_time_in < last_cyc_q;
  assign bus_adv  = wrapped ? bus_q + 32'(WRAP_STEP) : bus_q;
  assign sample   = req_valid && !req_write && aligned && (sel_cyc || sel_bus);

  always_comb begin
    code_d  = RC_OK;
    rdata_d = '0;
    if (!aligned)                     code_d = RC_TYPE;
    else if (!mapped)                 code_d = RC_ADDR;
    else if (req_write && sel_cyc)    code_d = RC_TYPE;
    else if (!req_write) begin
      if (sel_sec)       rdata_d = {29'd0, sec_q};
      else if (sel_tick) rdata_d = {ticks_q, {TICK_LSB{1'b0}}};
      else if (sel_cyc)  rdata_d = cycle_time_in;
      else               rdata_d = bus_adv | (cycle_time_in >> SPLICE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q      <= '0;
      ticks_q    <= TICK_W'(RESET_TICKS);
      bus_q      <= '0;
      last_cyc_q <= '0;
      rsp_valid  <= 1'b0;
      rsp_code   <= RC_OK;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_code  <= code_d;
        rsp_rdata <= rdata_d;
      end
      if (sample) begin
        bus_q      <= bus_adv;
        last_cyc_q <= cycle_time_in;
      end
      if (req_valid && req_write && aligned) begin
        if (sel_sec)  sec_q   <= req_wdata[2:0];
        if (sel_tick) ticks_q <= req_wdata[31:TICK_LSB];
        if (sel_bus)  bus_q   <= {req_wdata[31:7], 7'd0};
      end
    end
  end

  assign raw_us    = EXP_W'(sec_q) * EXP_W'(US_PER_SEC) + EXP_W'(ticks_q) * EXP_W'(US_PER_TICK);
  assign expire_us = (raw_us < EXP_W'(MIN_EXPIRE_US)) ? EXP_W'(MIN_EXPIRE_US) : raw_us;

  p_expire_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire_us >= EXP_W'(MIN_EXPIRE_US));
  p_rsp_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_err_zero_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != RC_OK) |-> rsp_rdata == 32'd0);
  p_misaligned_type_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] != 2'b00) |=> (rsp_code == RC_TYPE));
  p_misaligned_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !aligned) |=> ($stable(sec_q) && $stable(ticks_q) && $stable(bus_q)));
  p_idle_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(bus_q));
  p_wrap_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && sel_bus && wrapped) |=> bus_q == $past(bus_q) + 32'(WRAP_STEP));
endmodule

// File: tb/tb_split_bustime_regs.sv
module tb_split_bustime_regs;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_W = 24;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [7:0]  req_addr = 0;
  logic [9:0]  req_len = 0;
  logic [31:0] req_wdata = 0, cycle_time_in = 0;
  logic rsp_valid;
  logic [1:0] rsp_code;
  logic [31:0] rsp_rdata;
  logic [EXP_W-1:0] expire_us;

  split_bustime_regs dut (.clk, .rst_n, .req_valid, .req_write, .req_addr, .req_len,
    .req_wdata, .cycle_time_in, .rsp_valid, .rsp_code, .rsp_rdata, .expire_us);

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [2:0]  m_sec = 0;
  logic [12:0] m_tick = 800;
  logic [31:0] m_bus = 0, m_last = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_exp();
    int v = int'(m_sec) * 1000000 + int'(m_tick) * 125;
    return (v < 100000) ? 32'd100000 : 32'(v);
  endfunction

  task automatic access(string tag, bit wr, logic [7:0] a, logic [9:0] len,
                        logic [31:0] wd, logic [31:0] cyc);
    logic [1:0] ec; logic [31:0] ed;
    ec = 0; ed = 0;
    if (a[1:0] != 0 || len[1:0] != 0) ec = 1;
    else if (a >= 8'h10) ec = 2;
    else if (wr) begin
      case (a[3:2])
        0: m_sec = wd[2:0];
        1: m_tick = wd[31:19];
        2: ec = 1;
        default: m_bus = {wd[31:7], 7'd0};
      endcase
    end else begin
      case (a[3:2])
        0: ed = {29'd0, m_sec};
        1: ed = {m_tick, 19'd0};
        default: begin
          if (cyc < m_last) m_bus = m_bus + 128;
          m_last = cyc;
          ed = (a[3:2] == 2) ? cyc : (m_bus | (cyc >> 25));
        end
      endcase
    end
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_len = len;
    req_wdata = wd; cycle_time_in = cyc;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " valid"}, {31'd0, rsp_valid}, 1);
    chk({tag, " code"}, {30'd0, rsp_code}, {30'd0, ec});
    chk({tag, " data"}, rsp_rdata, ed);
    chk({tag, " expire"}, 32'(expire_us), model_exp());
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    chk("R1 expire", 32'(expire_us), 100000);
    access("R1 sec", 0, 8'h0, 4, 0, 0);
    access("R1 tick", 0, 8'h4, 4, 0, 0);
    access("R1 bus", 0, 8'hC, 4, 0, 0);
    // R2 R3 R4 masks and expiry sweep
    for (int s = 0; s < 8; s++) begin
      access("R2 sec wr", 1, 8'h0, 4, 32'hFFFF_FFF8 | 32'(s), 0);
      access("R2 sec rd", 0, 8'h0, 4, 0, 0);
      for (int k = 0; k < 8; k++) begin
        int t;
        t = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 799 : (k == 3) ? 800 :
            (k == 4) ? 801 : (k == 5) ? 4096 : (k == 6) ? 8190 : 8191;
        access("R3 tick wr", 1, 8'h4, 4, {13'(t), 19'h7FFFF}, 0);
        access("R4 tick rd", 0, 8'h4, 4, 0, 0);
      end
    end
    // R5 R6 wrap and splice
    access("R5 cyc", 0, 8'h8, 4, 0, 32'd100);
    access("R5 cyc wrap", 0, 8'h8, 4, 0, 32'd50);
    access("R6 no wrap", 0, 8'hC, 4, 0, 32'd50);
    access("R6 grow", 0, 8'hC, 4, 0, 32'hFFFF_FFF0);
    access("R6 wrap splice", 0, 8'hC, 4, 0, 32'hFE00_0000);
    access("R6 wrap small", 0, 8'hC, 4, 0, 32'd3);
    // R7 bus write mask, then wrap on top
    access("R7 bus wr", 1, 8'hC, 4, 32'hFFFF_FFFF, 32'd0);
    access("R7 bus rd", 0, 8'hC, 4, 0, 32'd1);
    access("R7 bus wr2", 1, 8'hC, 4, 32'h1234_56FF, 32'd0);
    access("R6 bus wrap", 0, 8'hC, 4, 0, 32'd0);
    // R9 write to cycle rejected
    access("R9 cyc wr", 1, 8'h8, 4, 32'hDEAD_BEEF, 0);
    access("R9 bus after", 0, 8'hC, 4, 0, 32'd0);
    // R8 length sweep
    for (int l = 0; l < 16; l++) access("R8 len", 0, 8'h0, 10'(l), 0, 0);
    for (int l = 1; l < 4; l++) access("R8 len wr", 1, 8'h0, 10'(l), 32'h5, 0);
    // R8 R10 R11 address sweeps
    for (int a = 0; a < 256; a++) access("R10 rd sweep", 0, 8'(a), 4, 0, 32'(a * 16777216));
    for (int a = 0; a < 256; a++) access("R10 wr sweep", 1, 8'(a), 4, 32'hA5A5_5A5A ^ 32'(a), 0);
    access("R11 sec rd", 0, 8'h0, 4, 0, 0);
    access("R11 tick rd", 0, 8'h4, 4, 0, 0);
    access("R11 bus rd", 0, 8'hC, 4, 0, 32'd7);
    @(negedge clk);
    chk("R11 idle", {31'd0, rsp_valid}, 0);
    finish_run();
  end
endmodule